// File: doc/BRIEF.md
# Dual-Bank Configurable Interrupt Controller

This block collects 32 interrupt request lines and turns them into two active-high request outputs, one for the ordinary interrupt path and one for the fast interrupt path. Each path is served by its own bank of registers. The two banks are identical and work independently. Inside a bank, software picks how each line is detected: as a level that is active high, as a level that is active low, as a rising edge or as a falling edge. Edge events are held in a latch until software acknowledges them. An enable mask then decides which pending lines may raise the bank's request.

The input lines pass through a two-stage synchronizer before any detection, so they may be asynchronous to the block's clock. Software reaches the registers over a simple bus with single-cycle reads and writes. A read returns its data combinationally in the same cycle, and a write takes effect at the clock edge. Software finds the lines that need service by reading a bank's status word. More than one status bit can be set at a time. Working out which line to serve first is left to software.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, every register of both banks reads 0, both request outputs are low, and all lines are masked, level-detected and active high.
- R2: Byte offsets 0x00 to 0x14 address the normal bank and 0x20 to 0x34 address the fast bank. Within a bank the offsets are: +0x00 source (read only), +0x04 mask, +0x08 clear (write only, reads 0), +0x0C mode, +0x10 polarity, +0x14 status (read only). Mask, mode and polarity read back what was written. Offsets +0x18 and +0x1C of either bank read 0 and ignore writes.
- R3: With a mode bit of 0, line n is pending while its synchronized input is 1 if polarity bit n is 0, and while the input is 0 if polarity bit n is 1.
- R4: With a mode bit of 1, a 0-to-1 transition (polarity 1) or a 1-to-0 transition (polarity 0) of the synchronized input sets the line's latch. The line then stays pending after the input returns to its idle value.
- R5: Writing 1 to bit n of the clear register clears line n's latch. Writing 0 to bit n leaves the latch unchanged.
- R6: If a qualifying edge and a clear of the same line fall in the same cycle, the latch ends up set.
- R7: The source register returns the unmasked pending vector. The status register returns the pending vector ANDed with the mask, so a mask bit of 1 enables its line, and a mask of all zeros makes the bank's request low.
- R8: irq_o is 1 exactly when the normal bank's status is nonzero, and fiq_o is 1 exactly when the fast bank's status is nonzero. Configuring one bank has no effect on the other bank's output.
- R9: An input change that the clock samples at edge k appears in the source register after edge k+1 and not before. A qualifying edge sets the latch at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, bit n is line n |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq_lines | input | 32 | Raw interrupt inputs |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
The sweep covers every line under all four detection settings in each bank. A swapped polarity or mode decode would show the wrong pending bit for one of the settings. A latch that ignores the edge type would fire on the edge the line should not react to. The sweep also writes a clear whose only zero bit is the target line, which catches a clear that acts on zeros or on the whole word. A directed case writes a clear in the same cycle as a fresh edge: a design that gives priority to the clear would drop that event. Other cases sample one cycle before and at the synchronizer latency, so an extra or a missing flop changes the result, and they check that one bank's settings never drive the other bank's output.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    RIDX_SOURCE = 3'd0,
    RIDX_ENABLE = 3'd1,
    RIDX_ACK    = 3'd2,
    RIDX_MODE   = 3'd3,
    RIDX_POL    = 3'd4,
    RIDX_STATUS = 3'd5
  } reg_idx_e;

  localparam int NUM_BANKS = 2;

  // level detection: active when the input differs from the polarity bit
  function automatic logic level_active(input logic cur, input logic pol);
    return cur ^ pol;
  endfunction

  // edge detection: pol=1 rising, pol=0 falling
  function automatic logic edge_seen(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] sync_prev
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_out  = stage2_q;
  assign sync_prev = prev_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_now,
  input  logic [LINES-1:0] line_prev,
  input  logic             wr_enable,
  input  logic             wr_mode,
  input  logic             wr_pol,
  input  logic             wr_ack,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] enable_q,
  output logic [LINES-1:0] mode_q,
  output logic [LINES-1:0] pol_q,
  output logic [LINES-1:0] source,
  output logic [LINES-1:0] status,
  output logic             req
);
  logic [LINES-1:0] latch_q;
  logic [LINES-1:0] edge_hit;
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] ack_vec;
  logic [LINES-1:0] level_vec;

  assign ack_vec = wr_ack ? wdata : '0;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign edge_hit[i]  = edge_seen(line_now[i], line_prev[i], pol_q[i]);
    assign level_vec[i] = level_active(line_now[i], pol_q[i]);
    assign set_vec[i]   = edge_hit[i] & mode_q[i];
    assign source[i]    = mode_q[i] ? latch_q[i] : level_vec[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      mode_q   <= '0;
      pol_q    <= '0;
      latch_q  <= '0;
    end else begin
      if (wr_enable) enable_q <= wdata;
      if (wr_mode)   mode_q   <= wdata;
      if (wr_pol)    pol_q    <= wdata;
      latch_q <= (latch_q & ~ack_vec) | set_vec;
    end
  end

  assign status = source & enable_q;
  assign req    = |status;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & $past(ack_vec & ~set_vec)) == '0); // R5
  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_vec) & ~latch_q) == '0); // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~$past(latch_q) & ~$past(set_vec)) == '0); // R4
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (enable_q != '0)); // R7
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  irq_lines,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int BANK_BIT = ADDR_W - 1;

  logic [LINES-1:0] line_now;
  logic [LINES-1:0] line_prev;

  logic [LINES-1:0] enable_q [NUM_BANKS];
  logic [LINES-1:0] mode_q   [NUM_BANKS];
  logic [LINES-1:0] pol_q    [NUM_BANKS];
  logic [LINES-1:0] source   [NUM_BANKS];
  logic [LINES-1:0] status   [NUM_BANKS];
  logic [NUM_BANKS-1:0] req;

  reg_idx_e reg_idx;
  logic     bank_pick;
  logic     wr_go;

  assign reg_idx   = reg_idx_e'(bus_addr[4:2]);
  assign bank_pick = bus_addr[BANK_BIT];
  assign wr_go     = bus_sel & bus_wr;

  intc_sync #(.WIDTH(LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (irq_lines),
    .sync_out (line_now),
    .sync_prev(line_prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_go & (bank_pick == b[0]);
    intc_bank #(.LINES(LINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_now (line_now),
      .line_prev(line_prev),
      .wr_enable(hit & (reg_idx == RIDX_ENABLE)),
      .wr_mode  (hit & (reg_idx == RIDX_MODE)),
      .wr_pol   (hit & (reg_idx == RIDX_POL)),
      .wr_ack   (hit & (reg_idx == RIDX_ACK)),
      .wdata    (bus_wdata),
      .enable_q (enable_q[b]),
      .mode_q   (mode_q[b]),
      .pol_q    (pol_q[b]),
      .source   (source[b]),
      .status   (status[b]),
      .req      (req[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (reg_idx)
        RIDX_SOURCE: bus_rdata = source[bank_pick];
        RIDX_ENABLE: bus_rdata = enable_q[bank_pick];
        RIDX_MODE:   bus_rdata = mode_q[bank_pick];
        RIDX_POL:    bus_rdata = pol_q[bank_pick];
        RIDX_STATUS: bus_rdata = status[bank_pick];
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];

  AST_IRQ_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q[0] == '0) |-> !irq_o); // R8
  AST_FIQ_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q[1] == '0) |-> !fiq_o); // R8
endmodule

// File: tb/test_intc_dual_bank.sv
module test_intc_dual_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines = '0;
  logic        irq_o;
  logic        fiq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  intc_dual_bank i_intc_dual_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] offs(input int bank, input int idx);
    return 6'(bank * 32 + idx * 4);
  endfunction

  task automatic wr(input int bank, input int idx, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = offs(bank, idx); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int bank, input int idx, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = offs(bank, idx);
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // register indices: 0 source, 1 mask, 2 clear, 3 mode, 4 polarity, 5 status
  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) begin
        rd(b, r, v); check("R1 reset read", v, 32'h0);
      end
    check("R1 irq_o low", {31'b0, irq_o}, 32'h0);
    check("R1 fiq_o low", {31'b0, fiq_o}, 32'h0);

    // R2: readback and unmapped slots
    for (int b = 0; b < 2; b++) begin
      for (int r = 1; r < 5; r++) begin
        if (r == 2) continue;
        pat = 32'h3C5A_0000 ^ (b * 32'h0101_0101) ^ (r * 32'h1111);
        wr(b, r, pat); rd(b, r, v); check("R2 readback", v, pat);
        wr(b, r, 32'h0);
      end
      wr(b, 6, 32'hFFFF_FFFF); rd(b, 6, v); check("R2 unmapped 0x18", v, 0);
      wr(b, 7, 32'hFFFF_FFFF); rd(b, 7, v); check("R2 unmapped 0x1C", v, 0);
      rd(b, 2, v); check("R2 clear reads 0", v, 0);
    end

    // R7: source unmasked, status masked (level, active high)
    irq_lines = 32'hA5A5_0F0F;
    wr(0, 1, 32'hFFFF_0000);
    settle(3);
    rd(0, 0, v); check("R7 source", v, 32'hA5A5_0F0F);
    rd(0, 5, v); check("R7 status", v, 32'hA5A5_0000);
    check("R8 irq_o from status", {31'b0, irq_o}, 32'h1);
    check("R8 fiq_o untouched", {31'b0, fiq_o}, 32'h0);
    wr(0, 1, 32'h0);
    check("R7 mask zero quiets", {31'b0, irq_o}, 32'h0);
    irq_lines = 0;
    settle(3);

    // R9: synchronizer latency
    @(negedge clk); irq_lines = 32'h0000_0010;
    @(posedge clk); @(negedge clk);
    rd(0, 0, v); check("R9 not visible after one edge", v, 0);
    @(posedge clk); @(negedge clk);
    rd(0, 0, v); check("R9 visible after two edges", v, 32'h10);
    irq_lines = 0;
    settle(3);

    // R6: edge and clear in the same cycle (bank 0, line 3 rising)
    wr(0, 3, 32'h8); wr(0, 4, 32'h8);
    irq_lines = 32'h8; settle(4);
    irq_lines = 0; settle(4);
    rd(0, 0, v); check("R4 latch held", v, 32'h8);
    irq_lines = 32'h8;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(0, 2, 32'h8);
    rd(0, 0, v); check("R6 edge beats clear", v, 32'h8);
    wr(0, 2, 32'h8);
    rd(0, 0, v); check("R5 plain clear", v, 32'h0);
    irq_lines = 0; settle(4);
    wr(0, 2, 32'hFFFF_FFFF);
    wr(0, 3, 0); wr(0, 4, 0);

    // Sweep: bank x config x line. cfg 0 level-high, 1 level-low, 2 rising, 3 falling
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 4; c++)
        for (int n = 0; n < 32; n++) begin
          logic [31:0] bit_n;
          bit lvl, pl;
          logic ea, eb, ec;
          bit_n = 32'h1 << n;
          lvl = (c < 2);
          pl  = (c == 1) || (c == 2);
          ea = lvl ? pl : 1'b0;
          eb = lvl ? ~pl : pl;
          ec = lvl ? pl : 1'b1;
          wr(b, 3, lvl ? 32'h0 : bit_n);
          wr(b, 4, pl ? bit_n : 32'h0);
          wr(b, 1, bit_n);
          settle(2);
          wr(b, 2, 32'hFFFF_FFFF);
          rd(b, 0, v); check(lvl ? "R3 idle" : "R4 idle", v, ea ? bit_n : 0);
          irq_lines = bit_n; settle(3);
          rd(b, 5, v); check(lvl ? "R3 asserted" : "R4 first edge", v, eb ? bit_n : 0);
          check("R8 own output", {31'b0, (b == 0) ? irq_o : fiq_o}, {31'b0, eb});
          check("R8 other output", {31'b0, (b == 0) ? fiq_o : irq_o}, 32'h0);
          irq_lines = 0; settle(3);
          rd(b, 0, v); check(lvl ? "R3 released" : "R4 second edge", v, ec ? bit_n : 0);
          if (!lvl) begin
            wr(b, 2, ~bit_n);
            rd(b, 0, v); check("R5 zero bit no effect", v, bit_n);
            wr(b, 2, bit_n);
            rd(b, 0, v); check("R5 one bit clears", v, 0);
          end
          wr(b, 1, 0); wr(b, 3, 0); wr(b, 4, 0);
        end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule